// File: doc/BRIEF.md
# Banked Interrupt Controller Register Front End

This block is the register front end of an extended I/O interrupt controller that serves 256 interrupt sources across 4 cores. A requester sends one access per handshake: read or write, a byte offset, a length of 1, 2, 4 or 8 bytes, its own core number and write data. The block decodes the offset into one of six register windows inside the main region, holds the window contents, and answers one cycle later with read data and an error flag.

The windows hold node type bytes, a small interrupt-pin map, enable bits, bounce bits, a per-core pending-status bank and one routing byte per source. The pending-status window is banked: the bank used is the requester's core, not the address. Status bits are raised by the routing logic through a set port and cleared by software writing ones. Each accepted main-region write is also forwarded to the routing logic as a byte-enabled strobe.

A separate small configuration space holds a read-only feature word and a configuration word. The configuration word can only be changed while its enable bit is clear (or to zero at any time), and whatever is stored is masked by the feature bits. The configuration word is exported so the routing logic can choose its encoding modes.

Top module: `xirq_regfront`

## Requirements
- R1: After reset the response is idle, `req_ready` is 1, every window byte and the configuration word are 0, and the feature word reads 0xF.
- R2: `req_ready` is high when no response is waiting or `rsp_ready` is high; an accepted request yields `rsp_valid` on the next clock edge, and a response that is not taken holds its data and error flag unchanged.
- R3: The main region begins at address 0x1400; windows lie at these offsets from it: node type 0xA0..0xBF (code 1), pin map 0xC0..0xC7 (code 2), enable 0x200..0x21F (code 3), bounce 0x280..0x29F (code 4), core status 0x400..0x41F (code 5), routing bytes 0x800..0x8FF (code 6). Writes store bytes that later reads return, little-endian (the byte at the lowest address is in bits 7:0).
- R4: Only lengths 1, 2, 4 and 8 are legal; any other length gives an error, zero read data and no change of state.
- R5: An address that is not a multiple of the length gives an error and changes nothing.
- R6: A main-region address outside all six windows, or outside the main region, gives an error with read data 0 and changes nothing.
- R7: The core status window reads and writes the bank of `req_core`; the same address from another core reaches another bank.
- R8: A status write clears each bit written as 1 and keeps the others; `set_valid` sets bit `set_src[2:0]` of byte `set_src[7:3]` in bank `set_core`, and a set wins over a clear of the same bit in the same cycle.
- R9: Each error-free main-region write pulses `wr_valid` together with its response, carrying the window code of R3, the byte offset inside the window, a byte enable with the lowest `req_len` bits set, the write data and the requester core.
- R10: In the configuration space (`req_virt`=1) offset 0x0 is the feature word, reading 0xF; a write to it gives an error and changes nothing.
- R11: Offset 0x4 is the configuration word (bit 1 enable, bit 2 source encoding, bit 3 core encoding); a nonzero write while bit 1 is set gives an error and changes nothing, otherwise the stored value is the written low 32 bits ANDed with the feature mask, shown on `cfg_mode`.
- R12: Configuration-space accesses must be 4 bytes and 4-byte aligned, otherwise they give an error; other aligned offsets read 0 without error and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_virt | input | 1 | 1 selects the configuration space, 0 the main region |
| req_addr | input | 16 | Byte address |
| req_len | input | 4 | Access length in bytes |
| req_core | input | 2 | Requesting core |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Read data, zero on writes and errors |
| rsp_err | output | 1 | Access refused |
| set_valid | input | 1 | Raise one status bit |
| set_core | input | 2 | Bank of the status bit to raise |
| set_src | input | 8 | Source number of the status bit to raise |
| wr_valid | output | 1 | Main-region write strobe |
| wr_window | output | 3 | Window code of the write |
| wr_offset | output | 8 | Byte offset inside the window |
| wr_be | output | 8 | Byte enable of the write |
| wr_data | output | 64 | Write data |
| wr_core | output | 2 | Requesting core of the write |
| cfg_mode | output | 4 | Stored configuration word |

## Verification
The bench aims at byte order and sub-word reads of a wide write, where a swapped lane order returns the wrong byte, and at window edges and gaps, where an off-by-one decode would accept an address next to a window or refuse its last byte. It drives the same status address from different cores and a set colliding with a write-one clear, which a design indexing the bank by address or letting the clear win would get wrong. It also walks the configuration word through its locked and unlocked states, catching a lock that ignores a zero write, a missing feature mask, or a feature word that can be overwritten, and stalls a response to see it hold.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

   // window codes seen on wr_window
   localparam logic [2:0] XRF_WIN_NONE    = 3'd0;
   localparam logic [2:0] XRF_WIN_NODE    = 3'd1;
   localparam logic [2:0] XRF_WIN_PINMAP  = 3'd2;
   localparam logic [2:0] XRF_WIN_ENABLE  = 3'd3;
   localparam logic [2:0] XRF_WIN_BOUNCE  = 3'd4;
   localparam logic [2:0] XRF_WIN_STATUS  = 3'd5;
   localparam logic [2:0] XRF_WIN_ROUTE   = 3'd6;
   localparam int unsigned XRF_NUM_WIN    = 6;

   // window starts relative to the main base
   localparam int unsigned XRF_NODE_START   = 32'h0A0;
   localparam int unsigned XRF_NODE_BYTES   = 32;
   localparam int unsigned XRF_PINMAP_START = 32'h0C0;
   localparam int unsigned XRF_PINMAP_BYTES = 8;
   localparam int unsigned XRF_ENABLE_START = 32'h200;
   localparam int unsigned XRF_BOUNCE_START = 32'h280;
   localparam int unsigned XRF_STATUS_START = 32'h400;
   localparam int unsigned XRF_ROUTE_START  = 32'h800;

   // configuration space offsets
   localparam int unsigned XRF_FEAT_OFF = 32'h0;
   localparam int unsigned XRF_CFG_OFF  = 32'h4;

   function automatic logic xrf_len_legal(input logic [3:0] n);
      return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
   endfunction

endpackage

// File: rtl/xrf_decode.sv
module xrf_decode
   import xrf_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 256,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MAIN_BASE = 32'h1400,
   parameter int unsigned MAIN_SPAN = 32'h0900
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        len,
   output logic [2:0]        win,
   output logic [7:0]        woff,
   output logic              size_ok,
   output logic              align_ok
);
   localparam int unsigned SRC_BYTES = NUM_SRC / 8;

   function automatic int unsigned win_start(input int unsigned k);
      case (k)
         0:       return XRF_NODE_START;
         1:       return XRF_PINMAP_START;
         2:       return XRF_ENABLE_START;
         3:       return XRF_BOUNCE_START;
         4:       return XRF_STATUS_START;
         default: return XRF_ROUTE_START;
      endcase
   endfunction

   function automatic int unsigned win_bytes(input int unsigned k);
      case (k)
         0:       return XRF_NODE_BYTES;
         1:       return XRF_PINMAP_BYTES;
         2, 3, 4: return SRC_BYTES;
         default: return NUM_SRC;
      endcase
   endfunction

   logic [31:0] abs32;
   logic [31:0] rel;
   logic        in_main;

   assign abs32   = 32'(addr);
   assign rel     = abs32 - MAIN_BASE;
   assign in_main = (abs32 >= MAIN_BASE) && (abs32 < MAIN_BASE + MAIN_SPAN);

   always_comb begin
      win  = XRF_WIN_NONE;
      woff = '0;
      for (int unsigned k = 0; k < XRF_NUM_WIN; k++) begin
         if (in_main && rel >= win_start(k) && rel < win_start(k) + win_bytes(k)) begin
            win  = 3'(k + 1);
            woff = 8'(rel - win_start(k));
         end
      end
   end

   assign size_ok  = xrf_len_legal(len);
   assign align_ok = (addr[3:0] & (len - 4'd1)) == 4'd0;

endmodule

// File: rtl/xrf_store.sv
module xrf_store #(
   parameter int unsigned NUM_SRC  = 256,
   parameter int unsigned NUM_CORE = 4,
   parameter int unsigned LIN_W    = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LIN_W-1:0]            rd_lin,
   input  logic [3:0]                  rd_len,
   output logic [63:0]                 rd_data,
   input  logic                        we,
   input  logic [LIN_W-1:0]            wr_lin,
   input  logic [3:0]                  wr_len,
   input  logic [63:0]                 wr_data,
   input  logic                        set_valid,
   input  logic [$clog2(NUM_CORE)-1:0] set_core,
   input  logic [$clog2(NUM_SRC)-1:0]  set_src
);
   localparam int unsigned SRC_BYTES = NUM_SRC / 8;
   localparam int unsigned SRC_W     = $clog2(NUM_SRC);
   localparam int unsigned CORE_W    = $clog2(NUM_CORE);
   localparam int unsigned LB_STATUS = 40 + 2 * SRC_BYTES + NUM_SRC;
   localparam int unsigned TOTAL     = LB_STATUS + NUM_CORE * SRC_BYTES;

   logic [7:0] mem [TOTAL];

   // read port: lanes beyond the length or the store read as zero
   for (genvar k = 0; k < 8; k++) begin : g_rd
      logic [LIN_W-1:0] ra;
      assign ra = rd_lin + LIN_W'(k);
      assign rd_data[8*k +: 8] = (4'(k) < rd_len && ra < LIN_W'(TOTAL)) ? mem[ra] : 8'h00;
   end

   // one register per byte; status bytes are clear-on-one and settable
   for (genvar i = 0; i < TOTAL; i++) begin : g_byte
      logic [LIN_W-1:0] rel;
      logic             hit;
      logic [7:0]       din;
      logic [7:0]       q;
      logic [7:0]       nxt;

      assign rel = LIN_W'(i) - wr_lin;
      assign hit = we && (wr_lin <= LIN_W'(i)) && (rel < LIN_W'(wr_len));
      assign din = wr_data[8*rel[2:0] +: 8];

      if (i >= LB_STATUS) begin : g_w1c
         localparam int unsigned BANK = (i - LB_STATUS) / SRC_BYTES;
         localparam int unsigned BIDX = (i - LB_STATUS) % SRC_BYTES;
         logic [7:0] setb;
         assign setb = (set_valid && set_core == CORE_W'(BANK) &&
                        set_src[SRC_W-1:3] == (SRC_W-3)'(BIDX)) ?
                       8'(8'd1 << set_src[2:0]) : 8'h00;
         assign nxt  = (hit ? (q & ~din) : q) | setb;
      end else begin : g_plain
         assign nxt = hit ? din : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= nxt;
      end

      assign mem[i] = q;
   end

endmodule

// File: rtl/xrf_virt.sv
module xrf_virt
   import xrf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [3:0]  FEAT_MASK = 4'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        len,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              err,
   output logic [3:0]        cfg
);
   logic legal, sel_feat, sel_cfg, locked_try;

   assign legal      = (len == 4'd4) && (addr[1:0] == 2'b00);
   assign sel_feat   = 32'(addr) == XRF_FEAT_OFF;
   assign sel_cfg    = 32'(addr) == XRF_CFG_OFF;
   assign locked_try = wr && sel_cfg && cfg[1] && (wdata != 32'h0);
   assign err        = !legal || (wr && sel_feat) || locked_try;

   always_comb begin
      rdata = '0;
      if (legal && sel_feat)     rdata = {28'h0, FEAT_MASK};
      else if (legal && sel_cfg) rdata = {28'h0, cfg};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= '0;
      else if (acc && wr && sel_cfg && !err)
         cfg <= wdata[3:0] & FEAT_MASK;
   end

endmodule

// File: rtl/xirq_regfront.sv
module xirq_regfront
   import xrf_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 256,
   parameter int unsigned NUM_CORE  = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MAIN_BASE = 32'h1400,
   parameter int unsigned MAIN_SPAN = 32'h0900,
   parameter logic [3:0]  FEAT_MASK = 4'hF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_write,
   input  logic                        req_virt,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [3:0]                  req_len,
   input  logic [$clog2(NUM_CORE)-1:0] req_core,
   input  logic [63:0]                 req_wdata,
   output logic                        rsp_valid,
   input  logic                        rsp_ready,
   output logic [63:0]                 rsp_rdata,
   output logic                        rsp_err,
   input  logic                        set_valid,
   input  logic [$clog2(NUM_CORE)-1:0] set_core,
   input  logic [$clog2(NUM_SRC)-1:0]  set_src,
   output logic                        wr_valid,
   output logic [2:0]                  wr_window,
   output logic [7:0]                  wr_offset,
   output logic [7:0]                  wr_be,
   output logic [63:0]                 wr_data,
   output logic [$clog2(NUM_CORE)-1:0] wr_core,
   output logic [3:0]                  cfg_mode
);
   localparam int unsigned SRC_BYTES = NUM_SRC / 8;
   localparam int unsigned LB_NODE   = 0;
   localparam int unsigned LB_PINMAP = LB_NODE + XRF_NODE_BYTES;
   localparam int unsigned LB_ENABLE = LB_PINMAP + XRF_PINMAP_BYTES;
   localparam int unsigned LB_BOUNCE = LB_ENABLE + SRC_BYTES;
   localparam int unsigned LB_ROUTE  = LB_BOUNCE + SRC_BYTES;
   localparam int unsigned LB_STATUS = LB_ROUTE + NUM_SRC;
   localparam int unsigned TOTAL     = LB_STATUS + NUM_CORE * SRC_BYTES;
   localparam int unsigned LIN_W     = $clog2(TOTAL + 8);

   // elaboration checks on the parameter set
   if (NUM_SRC % 64 != 0 || NUM_SRC > 256 || NUM_SRC < 64) begin : g_bad_src
      $error("NUM_SRC must be 64, 128, 192 or 256");
   end
   if (NUM_CORE < 2 || NUM_CORE > 256) begin : g_bad_core
      $error("NUM_CORE must lie in 2..256");
   end
   if (MAIN_SPAN < XRF_ROUTE_START + NUM_SRC || ADDR_W < 12 ||
       MAIN_BASE + MAIN_SPAN > (1 << ADDR_W)) begin : g_bad_map
      $error("main region does not fit the address width or the windows");
   end

   logic [2:0]       win;
   logic [7:0]       woff;
   logic             size_ok, align_ok, main_ok, main_we, fire, acc_err, v_err;
   logic [LIN_W-1:0] lin;
   logic [63:0]      s_rdata, rd_next;
   logic [31:0]      v_rdata;
   logic [7:0]       be;

   xrf_decode #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .MAIN_SPAN(MAIN_SPAN)
   ) u_dec (
      .addr(req_addr), .len(req_len), .win(win), .woff(woff),
      .size_ok(size_ok), .align_ok(align_ok)
   );

   // linear byte position inside the store; status is banked by requester
   always_comb begin
      case (win)
         XRF_WIN_NODE:   lin = LIN_W'(LB_NODE + 32'(woff));
         XRF_WIN_PINMAP: lin = LIN_W'(LB_PINMAP + 32'(woff));
         XRF_WIN_ENABLE: lin = LIN_W'(LB_ENABLE + 32'(woff));
         XRF_WIN_BOUNCE: lin = LIN_W'(LB_BOUNCE + 32'(woff));
         XRF_WIN_ROUTE:  lin = LIN_W'(LB_ROUTE + 32'(woff));
         XRF_WIN_STATUS: lin = LIN_W'(LB_STATUS + SRC_BYTES * 32'(req_core) + 32'(woff));
         default:        lin = '0;
      endcase
   end

   assign req_ready = !rsp_valid || rsp_ready;
   assign fire      = req_valid && req_ready;
   assign main_ok   = size_ok && align_ok && (win != XRF_WIN_NONE);
   assign main_we   = fire && req_write && !req_virt && main_ok;

   xrf_store #(
      .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .LIN_W(LIN_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_lin(lin), .rd_len(req_len), .rd_data(s_rdata),
      .we(main_we), .wr_lin(lin), .wr_len(req_len), .wr_data(req_wdata),
      .set_valid(set_valid), .set_core(set_core), .set_src(set_src)
   );

   xrf_virt #(
      .ADDR_W(ADDR_W), .FEAT_MASK(FEAT_MASK)
   ) u_virt (
      .clk(clk), .rst_n(rst_n), .acc(fire && req_virt), .wr(req_write),
      .addr(req_addr), .len(req_len), .wdata(req_wdata[31:0]),
      .rdata(v_rdata), .err(v_err), .cfg(cfg_mode)
   );

   for (genvar k = 0; k < 8; k++) begin : g_be
      assign be[k] = 4'(k) < req_len;
   end

   assign acc_err = req_virt ? v_err : !main_ok;

   always_comb begin
      if (req_write || acc_err) rd_next = '0;
      else if (req_virt)        rd_next = {32'h0, v_rdata};
      else                      rd_next = s_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
         wr_valid  <= 1'b0;
         wr_window <= XRF_WIN_NONE;
         wr_offset <= '0;
         wr_be     <= '0;
         wr_data   <= '0;
         wr_core   <= '0;
      end else begin
         if (fire) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_next;
            rsp_err   <= acc_err;
         end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
         end
         wr_valid <= main_we;
         if (main_we) begin
            wr_window <= win;
            wr_offset <= woff;
            wr_be     <= be;
            wr_data   <= req_wdata;
            wr_core   <= req_core;
         end
      end
   end

endmodule

// File: rtl/xrf_chk.sv
module xrf_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [3:0]  FEAT_MASK = 4'hF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              req_virt,
   input logic [ADDR_W-1:0] req_addr,
   input logic [3:0]        req_len,
   input logic [31:0]       wdata_lo,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [63:0]       rsp_rdata,
   input logic              rsp_err,
   input logic              wr_valid,
   input logic [3:0]        cfg_mode
);
   logic fire, cfg_wr;
   assign fire   = req_valid && req_ready;
   assign cfg_wr = fire && req_write && req_virt && req_len == 4'd4 &&
                   32'(req_addr) == 32'h4;

   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);

   // R2
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

   // R6
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == 64'h0));

   // R4
   bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !(req_len == 4'd1 || req_len == 4'd2 || req_len == 4'd4 || req_len == 4'd8))
      |=> (rsp_err && !wr_valid));

   // R5
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_len == 4'd4 && req_addr[1:0] != 2'b00) |=> (rsp_err && !wr_valid));

   // R9
   strobe_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (rsp_valid && !rsp_err && !req_virt_q));

   // R10
   feat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_write && req_virt && req_len == 4'd4 && 32'(req_addr) == 32'h0)
      |=> (rsp_err && $stable(cfg_mode)));

   // R11
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_mode[1] && wdata_lo != 32'h0) |=> (rsp_err && $stable(cfg_mode)));

   // R11
   cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_mode[1]) |=> (!rsp_err && cfg_mode == ($past(wdata_lo[3:0]) & FEAT_MASK)));

   logic req_virt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    req_virt_q <= 1'b0;
      else if (fire) req_virt_q <= req_virt;
   end

endmodule

bind xirq_regfront xrf_chk #(
   .ADDR_W(ADDR_W), .FEAT_MASK(FEAT_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .req_virt(req_virt), .req_addr(req_addr),
   .req_len(req_len), .wdata_lo(req_wdata[31:0]), .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
   .wr_valid(wr_valid), .cfg_mode(cfg_mode)
);

// File: tb/xirq_regfront_tb.sv
module xirq_regfront_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_virt = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_len = '0;
   logic [1:0]  req_core = '0;
   logic [63:0] req_wdata = '0;
   logic        req_ready, rsp_valid, rsp_err, wr_valid;
   logic        rsp_ready = 1'b1;
   logic [63:0] rsp_rdata, wr_data;
   logic        set_valid = 1'b0;
   logic [1:0]  set_core = '0;
   logic [7:0]  set_src = '0;
   logic [2:0]  wr_window;
   logic [7:0]  wr_offset, wr_be;
   logic [1:0]  wr_core;
   logic [3:0]  cfg_mode;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   logic [63:0] g_data;
   logic        g_err, g_wv;

   always #(CLK_PERIOD/2) clk = ~clk;

   xirq_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_virt(req_virt), .req_addr(req_addr),
      .req_len(req_len), .req_core(req_core), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .set_valid(set_valid), .set_core(set_core),
      .set_src(set_src), .wr_valid(wr_valid), .wr_window(wr_window),
      .wr_offset(wr_offset), .wr_be(wr_be), .wr_data(wr_data),
      .wr_core(wr_core), .cfg_mode(cfg_mode)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // one access; response sampled on the following falling edge
   task automatic xfer(input bit wr, input bit vr, input logic [15:0] a,
                       input logic [3:0] n, input logic [1:0] c, input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_virt = vr; req_addr = a;
      req_len = n; req_core = c; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      g_data = rsp_rdata; g_err = rsp_err; g_wv = wr_valid;
   endtask

   task automatic rd_main(input string tag, input logic [15:0] a, input logic [3:0] n,
                          input logic [1:0] c, input logic [63:0] exp);
      xfer(1'b0, 1'b0, a, n, c, 64'h0);
      chk({tag, " data"}, g_data, exp);
      chk({tag, " err"}, {63'h0, g_err}, 64'h0);
   endtask

   task automatic expect_err(input string tag, input bit wr, input bit vr,
                             input logic [15:0] a, input logic [3:0] n, input logic [63:0] d);
      xfer(wr, vr, a, n, 2'd0, d);
      chk({tag, " err"}, {63'h0, g_err}, 64'h1);
      chk({tag, " zero data"}, g_data, 64'h0);
      chk({tag, " no strobe"}, {63'h0, g_wv}, 64'h0);
   endtask

   task automatic raise(input logic [1:0] c, input logic [7:0] s);
      @(negedge clk);
      set_valid = 1'b1; set_core = c; set_src = s;
      @(negedge clk);
      set_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rsp idle", {63'h0, rsp_valid}, 64'h0);
      chk("R1 ready", {63'h0, req_ready}, 64'h1);
      chk("R1 cfg", {60'h0, cfg_mode}, 64'h0);
      rd_main("R1 enable", 16'h1600, 4'd8, 2'd0, 64'h0);
      rd_main("R1 route", 16'h1CF8, 4'd8, 2'd0, 64'h0);
      xfer(1'b0, 1'b1, 16'h0000, 4'd4, 2'd0, 64'h0);
      chk("R1 feature", g_data, 64'hF);
   endtask

   task automatic t_windows();
      xfer(1'b1, 1'b0, 16'h1600, 4'd8, 2'd1, 64'h1122334455667788);
      chk("R9 strobe", {63'h0, g_wv}, 64'h1);
      chk("R9 window", {61'h0, wr_window}, 64'd3);
      chk("R9 offset", {56'h0, wr_offset}, 64'h0);
      chk("R9 be", {56'h0, wr_be}, 64'hFF);
      chk("R9 data", wr_data, 64'h1122334455667788);
      chk("R9 core", {62'h0, wr_core}, 64'd1);
      rd_main("R3 enable 8", 16'h1600, 4'd8, 2'd0, 64'h1122334455667788);
      rd_main("R3 enable byte3", 16'h1603, 4'd1, 2'd0, 64'h55);
      rd_main("R3 enable half", 16'h1602, 4'd2, 2'd0, 64'h5566);
      xfer(1'b1, 1'b0, 16'h14C4, 4'd4, 2'd0, 64'hA1B2C3D4);
      rd_main("R3 pinmap", 16'h14C0, 4'd8, 2'd0, 64'hA1B2C3D4_00000000);
      xfer(1'b1, 1'b0, 16'h14BE, 4'd2, 2'd0, 64'hBEEF);
      rd_main("R3 node top", 16'h14B8, 4'd8, 2'd0, 64'hBEEF_0000_0000_0000);
      xfer(1'b1, 1'b0, 16'h169C, 4'd4, 2'd0, 64'hCAFEF00D);
      rd_main("R3 bounce", 16'h169C, 4'd4, 2'd0, 64'hCAFEF00D);
      xfer(1'b1, 1'b0, 16'h1CFE, 4'd2, 2'd3, 64'h0302);
      chk("R9 route window", {61'h0, wr_window}, 64'd6);
      chk("R9 route offset", {56'h0, wr_offset}, 64'hFE);
      chk("R9 route be", {56'h0, wr_be}, 64'h03);
      rd_main("R3 route last", 16'h1CFF, 4'd1, 2'd0, 64'h03);
   endtask

   task automatic t_len_align();
      expect_err("R4 len3", 1'b1, 1'b0, 16'h1600, 4'd3, 64'hFFFF_FFFF);
      expect_err("R4 len0", 1'b0, 1'b0, 16'h1600, 4'd0, 64'h0);
      expect_err("R4 len5", 1'b1, 1'b0, 16'h1600, 4'd5, 64'hFFFF_FFFF);
      expect_err("R5 odd half", 1'b1, 1'b0, 16'h1601, 4'd2, 64'h0);
      expect_err("R5 word", 1'b1, 1'b0, 16'h1602, 4'd4, 64'h0);
      expect_err("R5 dword", 1'b1, 1'b0, 16'h1604, 4'd8, 64'h0);
      rd_main("R4 R5 unchanged", 16'h1600, 4'd8, 2'd0, 64'h1122334455667788);
   endtask

   task automatic t_range();
      expect_err("R6 base gap", 1'b0, 1'b0, 16'h1400, 4'd8, 64'h0);
      expect_err("R6 past pinmap", 1'b0, 1'b0, 16'h14C8, 4'd8, 64'h0);
      expect_err("R6 hole", 1'b0, 1'b0, 16'h1700, 4'd4, 64'h0);
      expect_err("R6 past region", 1'b0, 1'b0, 16'h1D00, 4'd1, 64'h0);
      expect_err("R6 below region", 1'b0, 1'b0, 16'h13F8, 4'd8, 64'h0);
      expect_err("R6 write hole", 1'b1, 1'b0, 16'h1620, 4'd8, 64'hFFFF);
      rd_main("R6 enable tail", 16'h1618, 4'd8, 2'd0, 64'h0);
   endtask

   task automatic t_status();
      raise(2'd2, 8'd10);
      rd_main("R7 core2", 16'h1800, 4'd2, 2'd2, 64'h0400);
      rd_main("R7 core1 same addr", 16'h1800, 4'd2, 2'd1, 64'h0);
      raise(2'd0, 8'd255);
      rd_main("R7 core0 top", 16'h1818, 4'd8, 2'd0, 64'h8000_0000_0000_0000);
      rd_main("R7 core3 top", 16'h1818, 4'd8, 2'd3, 64'h0);
      xfer(1'b1, 1'b0, 16'h1800, 4'd2, 2'd2, 64'hFBFF);
      chk("R9 status window", {61'h0, wr_window}, 64'd5);
      chk("R9 status core", {62'h0, wr_core}, 64'd2);
      rd_main("R8 zero keeps", 16'h1800, 4'd2, 2'd2, 64'h0400);
      xfer(1'b1, 1'b0, 16'h1800, 4'd2, 2'd2, 64'h0400);
      rd_main("R8 one clears", 16'h1800, 4'd2, 2'd2, 64'h0);
      rd_main("R8 other bank kept", 16'h1818, 4'd8, 2'd0, 64'h8000_0000_0000_0000);
      raise(2'd1, 8'd0);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_virt = 1'b0; req_addr = 16'h1800;
      req_len = 4'd1; req_core = 2'd1; req_wdata = 64'h01;
      set_valid = 1'b1; set_core = 2'd1; set_src = 8'd0;
      @(negedge clk);
      req_valid = 1'b0; set_valid = 1'b0;
      rd_main("R8 set wins", 16'h1800, 4'd1, 2'd1, 64'h01);
   endtask

   task automatic t_virt();
      xfer(1'b1, 1'b1, 16'h0000, 4'd4, 2'd0, 64'h0);
      chk("R10 feat write err", {63'h0, g_err}, 64'h1);
      xfer(1'b0, 1'b1, 16'h0000, 4'd4, 2'd0, 64'h0);
      chk("R10 feat kept", g_data, 64'hF);
      xfer(1'b1, 1'b1, 16'h0004, 4'd4, 2'd0, 64'hFFF5);
      chk("R11 masked write ok", {63'h0, g_err}, 64'h0);
      chk("R11 masked cfg", {60'h0, cfg_mode}, 64'h5);
      xfer(1'b1, 1'b1, 16'h0004, 4'd4, 2'd0, 64'h6);
      chk("R11 unlocked write", {60'h0, cfg_mode}, 64'h6);
      xfer(1'b1, 1'b1, 16'h0004, 4'd4, 2'd0, 64'h8);
      chk("R11 locked err", {63'h0, g_err}, 64'h1);
      chk("R11 locked keep", {60'h0, cfg_mode}, 64'h6);
      xfer(1'b0, 1'b1, 16'h0004, 4'd4, 2'd0, 64'h0);
      chk("R11 cfg read", g_data, 64'h6);
      xfer(1'b1, 1'b1, 16'h0004, 4'd4, 2'd0, 64'h0);
      chk("R11 zero while locked", {63'h0, g_err}, 64'h0);
      chk("R11 cleared", {60'h0, cfg_mode}, 64'h0);
      expect_err("R12 len8", 1'b0, 1'b1, 16'h0000, 4'd8, 64'h0);
      expect_err("R12 misaligned", 1'b0, 1'b1, 16'h0002, 4'd4, 64'h0);
      xfer(1'b1, 1'b1, 16'h0008, 4'd4, 2'd0, 64'hFF);
      chk("R12 other write ok", {63'h0, g_err}, 64'h0);
      chk("R12 other no strobe", {63'h0, g_wv}, 64'h0);
      xfer(1'b0, 1'b1, 16'h0008, 4'd4, 2'd0, 64'h0);
      chk("R12 other read zero", g_data, 64'h0);
      chk("R12 other read ok", {63'h0, g_err}, 64'h0);
   endtask

   task automatic t_hold();
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_write = 1'b0; req_virt = 1'b0; req_addr = 16'h1600;
      req_len = 4'd8; req_core = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 valid", {63'h0, rsp_valid}, 64'h1);
      chk("R2 not ready", {63'h0, req_ready}, 64'h0);
      chk("R2 data", rsp_rdata, 64'h1122334455667788);
      @(negedge clk);
      chk("R2 held valid", {63'h0, rsp_valid}, 64'h1);
      chk("R2 held data", rsp_rdata, 64'h1122334455667788);
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R2 released", {63'h0, rsp_valid}, 64'h0);
      chk("R2 ready again", {63'h0, req_ready}, 64'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_windows();
      t_len_align();
      t_range();
      t_status();
      t_virt();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      end
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule